// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block is the byte-wide register front end of a two-channel serial communications controller. A host reaches it through a small memory-mapped window of eight byte addresses. Each channel has a single control location and a single data location. The control location works indirectly: the first control write loads a register pointer. The next control access then targets the register that pointer names, and the pointer then drops back to zero on its own. A command field in register 0 can raise the pointer into the upper bank, or clear a channel's receive or transmit interrupt-pending flag. A write to register 9 issues a soft reset to channel A, to channel B, or to both.

Received bytes come in on a valid/ready stream per channel. A channel can hold exactly one byte, so `rx_ready` is high only while reception is enabled and the holding byte is empty. A byte is taken on any clock where `rx_valid` and `rx_ready` are both high. Accepted transmit bytes leave as a one-cycle `tx_valid` pulse with no back-pressure, so the sink must take every pulse. Both channels share one registered interrupt output. The transmit and receive pending flags of both channels can also be read together through channel A's read register 3. A break input per channel latches a break flag into read register 0.

Top module: `twin_serial_regif`

## Requirements
- R1: `bus_addr[2]`=1 selects channel A and 0 selects channel B. `bus_addr[1]`=0 is the control location and 1 is the data location. `bus_addr[0]` is ignored. During a read access (`bus_sel`=1, `bus_we`=0), `bus_rdata` shows the addressed value in that same cycle. It is 0 at all other times.
- R2: A control write while the pointer is 0 loads the pointer from `wdata[2:0]`. When `wdata[5:3]`=001, 8 is added to the loaded value, which reaches registers 8 to 15.
- R3: A control write made while the pointer is nonzero returns the pointer to 0. Any control read also returns it to 0.
- R4: With the pointer at 0, the command in `wdata[5:3]` clears pending flags: 100 clears receive pending, 101 clears transmit pending, and 111 clears both. The receive-available bit RR0[0] is not changed.
- R5: A write to register 9 takes `wdata[7:6]` as a reset code: 01 resets channel B, 10 resets channel A, and 11 resets both. The writing channel's pointer returns to 0.
- R6: After reset (the `rst` input or a soft reset), a channel has the following state. RR0 reads 0x44, RR1 reads 0x06, and the pointer is 0. Both pending flags are clear. Reception and transmission are disabled, and the interrupt enables in register 1 are off. The break-interrupt enable (register 15 bit 7) is on. After `rst`, `irq` is 0.
- R7: `irq` is a register loaded on every clock from the state before that edge. It is set when some channel has register 1 bit 0 set and at least one of the following holds: register 1 bit 1 is set and transmit is pending; register 1 bits 4:3 are 01 or 10 and receive is pending; register 15 bit 7 and RR0 bit 7 are both set.
- R8: Channel A's read register 3 reads {2'b00, A rx pending, A tx pending, 1'b0, B rx pending, B tx pending, 1'b0}. Channel B's read register 3 reads 0. Read registers other than 0, 1 and 3 read 0.
- R9: A data write is accepted only when register 5 bit 3 is set. An accepted write pulses `tx_valid` for one cycle after the write edge, with the byte on `tx_data`. It also sets RR0[2], RR1[0] and transmit pending. A write that is not accepted has no effect.
- R10: `rx_ready` equals register 3 bit 0 AND NOT RR0[0]. An accepted byte sets RR0[0] and receive pending, and a data read returns it. A data read clears RR0[0] and receive pending. When a byte is accepted in the same cycle as a clear, the set wins.
- R11: A high `brk_in` on a clock sets RR0[7]. The bit stays set until that channel is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of both channels |
| bus_sel | input | 1 | Access strobe, one access per cycle it is high |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Byte address within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rx_valid | input | 2 | Receive byte offered; bit 0 channel A, bit 1 channel B |
| rx_data | input | 16 | Receive bytes; [7:0] channel A, [15:8] channel B |
| rx_ready | output | 2 | Channel can take a byte this cycle |
| tx_valid | output | 2 | One-cycle transmit pulse per channel |
| tx_data | output | 16 | Transmit bytes; [7:0] channel A, [15:8] channel B |
| brk_in | input | 2 | Break detected, per channel |
| irq | output | 1 | Shared registered interrupt request |

## Verification
The hardest situation to reach is the reset of the other channel and the upper register bank. Both are reached only through a two-step pointer sequence: a point-high command followed by a write at pointer 9 or 15. A second hard situation is a byte accepted in the same cycle that a command or data read clears the receive state. The directed part of the stimulus walks each of these sequences in order and checks the resulting pointer, the read registers and the interrupt. A long random phase then mixes accesses, offered bytes and breaks on both channels. A behavioural model predicts every output on every clock, so the same-cycle collisions are compared wherever they occur.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int BYTE_W = 8;
  localparam int NCH    = 2;
  localparam int PTR_W  = 4;
  localparam int ADDR_W = 3;

  localparam logic CH_A = 1'b0;
  localparam logic CH_B = 1'b1;

  localparam logic [BYTE_W-1:0] RR0_INIT = 8'h44;
  localparam logic [BYTE_W-1:0] RR1_INIT = 8'h06;

  localparam logic [PTR_W-1:0] REG_IEN = 4'd1;
  localparam logic [PTR_W-1:0] REG_RXC = 4'd3;
  localparam logic [PTR_W-1:0] REG_TXC = 4'd5;
  localparam logic [PTR_W-1:0] REG_RST = 4'd9;
  localparam logic [PTR_W-1:0] REG_XIE = 4'd15;
  localparam logic [PTR_W-1:0] REG_ST0 = 4'd0;
  localparam logic [PTR_W-1:0] REG_ST1 = 4'd1;
  localparam logic [PTR_W-1:0] REG_PND = 4'd3;

  localparam logic [2:0] CMD_HI      = 3'b001;
  localparam logic [2:0] CMD_CLR_RX  = 3'b100;
  localparam logic [2:0] CMD_CLR_TX  = 3'b101;
  localparam logic [2:0] CMD_CLR_ALL = 3'b111;

  localparam int RR0_RXAV   = 0;
  localparam int RR0_TXE    = 2;
  localparam int RR0_BRK    = 7;
  localparam int RR1_SENT   = 0;
  localparam int WR3_RXEN   = 0;
  localparam int WR5_TXEN   = 3;
  localparam int WR15_BRKIE = 7;

  typedef struct packed {
    logic rx_mode_hi;
    logic rx_mode_lo;
    logic tx_ie;
    logic master_ie;
  } ien_t;

  function automatic logic irq_want(ien_t ie, logic tx_p, logic rx_p,
                                    logic brk_ie, logic brk_seen);
    return ie.master_ie &&
           ((ie.tx_ie && tx_p) ||
            ((ie.rx_mode_hi ^ ie.rx_mode_lo) && rx_p) ||
            (brk_ie && brk_seen));
  endfunction
endpackage

// File: rtl/sio_decode.sv
module sio_decode
  import sio_pkg::*;
(
  input  logic                      bus_sel,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:1]         bus_addr,
  input  logic [1:0]                rst_code,
  input  logic [NCH-1:0][PTR_W-1:0] ptr,
  output logic                      sel_ch,
  output logic [NCH-1:0]            ctl_wr,
  output logic [NCH-1:0]            ctl_rd,
  output logic [NCH-1:0]            dat_wr,
  output logic [NCH-1:0]            dat_rd,
  output logic [NCH-1:0]            soft_rst
);
  logic is_data;

  assign sel_ch  = bus_addr[2] ? CH_A : CH_B;
  assign is_data = bus_addr[1];

  always_comb begin
    ctl_wr   = '0;
    ctl_rd   = '0;
    dat_wr   = '0;
    dat_rd   = '0;
    soft_rst = '0;
    if (bus_sel) begin
      ctl_wr[sel_ch] = bus_we  && !is_data;
      ctl_rd[sel_ch] = !bus_we && !is_data;
      dat_wr[sel_ch] = bus_we  && is_data;
      dat_rd[sel_ch] = !bus_we && is_data;
    end
    if (ctl_wr[sel_ch] && (ptr[sel_ch] == REG_RST)) begin
      soft_rst[CH_A] = rst_code[1];
      soft_rst[CH_B] = rst_code[0];
    end
  end
endmodule

// File: rtl/sio_chan.sv
module sio_chan
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              ctl_wr,
  input  logic              ctl_rd,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              brk,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic [PTR_W-1:0]  ptr,
  output logic [BYTE_W-1:0] rr0,
  output logic [BYTE_W-1:0] rr1,
  output logic [BYTE_W-1:0] rx_hold,
  output logic              rx_pend,
  output logic              tx_pend,
  output logic              irq_req
);
  ien_t       ie_q;
  logic       rx_en_q;
  logic       tx_en_q;
  logic       brk_ie_q;
  logic [2:0] cmd;
  logic       clr_rx;
  logic       clr_tx;

  assign cmd      = wdata[5:3];
  assign clr_rx   = (cmd == CMD_CLR_RX) || (cmd == CMD_CLR_ALL);
  assign clr_tx   = (cmd == CMD_CLR_TX) || (cmd == CMD_CLR_ALL);
  assign rx_ready = rx_en_q && !rr0[RR0_RXAV];
  assign irq_req  = irq_want(ie_q, tx_pend, rx_pend, brk_ie_q, rr0[RR0_BRK]);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ptr      <= '0;
      rr0      <= RR0_INIT;
      rr1      <= RR1_INIT;
      rx_hold  <= '0;
      rx_pend  <= 1'b0;
      tx_pend  <= 1'b0;
      ie_q     <= '0;
      rx_en_q  <= 1'b0;
      tx_en_q  <= 1'b0;
      brk_ie_q <= 1'b1;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= 1'b0;
      if (ctl_wr) begin
        if (ptr == '0) begin
          ptr <= PTR_W'({(cmd == CMD_HI), wdata[2:0]});
          if (clr_rx) rx_pend <= 1'b0;
          if (clr_tx) tx_pend <= 1'b0;
        end else begin
          case (ptr)
            REG_IEN: ie_q     <= '{rx_mode_hi: wdata[4], rx_mode_lo: wdata[3],
                                   tx_ie: wdata[1], master_ie: wdata[0]};
            REG_RXC: rx_en_q  <= wdata[WR3_RXEN];
            REG_TXC: tx_en_q  <= wdata[WR5_TXEN];
            REG_XIE: brk_ie_q <= wdata[WR15_BRKIE];
            default: ;
          endcase
          ptr <= '0;
        end
      end
      if (ctl_rd) ptr <= '0;
      if (dat_wr && tx_en_q) begin
        tx_valid      <= 1'b1;
        tx_data       <= wdata;
        rr0[RR0_TXE]  <= 1'b1;
        rr1[RR1_SENT] <= 1'b1;
        tx_pend       <= 1'b1;
      end
      if (dat_rd) begin
        rr0[RR0_RXAV] <= 1'b0;
        rx_pend       <= 1'b0;
      end
      if (rx_valid && rx_ready) begin
        rr0[RR0_RXAV] <= 1'b1;
        rx_hold       <= rx_data;
        rx_pend       <= 1'b1;
      end
      if (brk) rr0[RR0_BRK] <= 1'b1;
    end
  end
endmodule

// File: rtl/twin_serial_regif.sv
module twin_serial_regif
  import sio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BYTE_W-1:0]     bus_wdata,
  output logic [BYTE_W-1:0]     bus_rdata,
  input  logic [NCH-1:0]        rx_valid,
  input  logic [NCH*BYTE_W-1:0] rx_data,
  output logic [NCH-1:0]        rx_ready,
  output logic [NCH-1:0]        tx_valid,
  output logic [NCH*BYTE_W-1:0] tx_data,
  input  logic [NCH-1:0]        brk_in,
  output logic                  irq
);
  logic [NCH-1:0][PTR_W-1:0] ch_ptr;
  logic [BYTE_W-1:0]         ch_rr0  [NCH];
  logic [BYTE_W-1:0]         ch_rr1  [NCH];
  logic [BYTE_W-1:0]         ch_hold [NCH];
  logic [NCH-1:0]            ch_rxp;
  logic [NCH-1:0]            ch_txp;
  logic [NCH-1:0]            ch_irq;
  logic [NCH-1:0]            ctl_wr, ctl_rd, dat_wr, dat_rd, soft_rst;
  logic                      sel_ch;
  logic [BYTE_W-1:0]         rr3_a;
  logic                      unused_addr0;

  assign unused_addr0 = bus_addr[0];

  sio_decode u_dec (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr[ADDR_W-1:1]),
    .rst_code (bus_wdata[7:6]),
    .ptr      (ch_ptr),
    .sel_ch   (sel_ch),
    .ctl_wr   (ctl_wr),
    .ctl_rd   (ctl_rd),
    .dat_wr   (dat_wr),
    .dat_rd   (dat_rd),
    .soft_rst (soft_rst)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sio_chan u_chan (
      .clk      (clk),
      .rst      (rst),
      .soft_rst (soft_rst[c]),
      .ctl_wr   (ctl_wr[c]),
      .ctl_rd   (ctl_rd[c]),
      .dat_wr   (dat_wr[c]),
      .dat_rd   (dat_rd[c]),
      .wdata    (bus_wdata),
      .rx_valid (rx_valid[c]),
      .rx_data  (rx_data[c*BYTE_W +: BYTE_W]),
      .rx_ready (rx_ready[c]),
      .brk      (brk_in[c]),
      .tx_valid (tx_valid[c]),
      .tx_data  (tx_data[c*BYTE_W +: BYTE_W]),
      .ptr      (ch_ptr[c]),
      .rr0      (ch_rr0[c]),
      .rr1      (ch_rr1[c]),
      .rx_hold  (ch_hold[c]),
      .rx_pend  (ch_rxp[c]),
      .tx_pend  (ch_txp[c]),
      .irq_req  (ch_irq[c])
    );
  end

  assign rr3_a = {2'b00, ch_rxp[CH_A], ch_txp[CH_A], 1'b0,
                  ch_rxp[CH_B], ch_txp[CH_B], 1'b0};

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      if (bus_addr[1]) begin
        bus_rdata = ch_hold[sel_ch];
      end else begin
        case (ch_ptr[sel_ch])
          REG_ST0: bus_rdata = ch_rr0[sel_ch];
          REG_ST1: bus_rdata = ch_rr1[sel_ch];
          REG_PND: bus_rdata = (sel_ch == CH_A) ? rr3_a : '0;
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |ch_irq;
  end
endmodule

// File: rtl/sio_regif_chk.sv
module sio_regif_chk
  import sio_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NCH-1:0]   rx_valid,
  input logic [NCH-1:0]   rx_ready,
  input logic [NCH-1:0]   tx_valid,
  input logic             irq,
  input logic [PTR_W-1:0] ptr_a
);
  // R10: a taken byte fills the holding slot
  p_rx_busy_r10_a: assert property (@(posedge clk) disable iff (rst)
    rx_valid[0] && rx_ready[0] |=> !rx_ready[0]);
  p_rx_busy_r10_b: assert property (@(posedge clk) disable iff (rst)
    rx_valid[1] && rx_ready[1] |=> !rx_ready[1]);

  // R9: transmit pulses only follow a data write to that channel
  p_tx_cause_r9_a: assert property (@(posedge clk) disable iff (rst)
    tx_valid[0] |-> $past(bus_sel && bus_we && (bus_addr[2:1] == 2'b11)));
  p_tx_cause_r9_b: assert property (@(posedge clk) disable iff (rst)
    tx_valid[1] |-> $past(bus_sel && bus_we && (bus_addr[2:1] == 2'b01)));

  // R6: interrupt low right after reset
  p_irq_reset_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !irq);

  // R3: pointer of channel A returns home
  p_ptr_rd_home_r3: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel && !bus_we && !bus_addr[1] && bus_addr[2]) |-> (ptr_a == '0));
  p_ptr_wr_home_r3: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel && bus_we && !bus_addr[1] && bus_addr[2] && (ptr_a != '0))
      |-> (ptr_a == '0));
endmodule

bind twin_serial_regif sio_regif_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_sel  (bus_sel),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .tx_valid (tx_valid),
  .irq      (irq),
  .ptr_a    (ch_ptr[0])
);

// File: tb/twin_serial_regif_tb_top.sv
module twin_serial_regif_tb_top;
  localparam int CLK_P = 10;
  localparam logic [2:0] A_CTL = 3'b100;
  localparam logic [2:0] A_DAT = 3'b110;
  localparam logic [2:0] B_CTL = 3'b000;
  localparam logic [2:0] B_DAT = 3'b010;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [1:0]  rx_valid = '0;
  logic [15:0] rx_data = '0;
  logic [1:0]  rx_ready;
  logic [1:0]  tx_valid;
  logic [15:0] tx_data;
  logic [1:0]  brk_in = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_ptr[2], m_rr0[2], m_rr1[2], m_wr1[2], m_rxen[2], m_txen[2];
  int m_bie[2], m_rxp[2], m_txp[2], m_rxb[2], m_txv[2], m_txd[2];
  int m_irq;

  always #(CLK_P/2) clk = ~clk;

  twin_serial_regif dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .brk_in(brk_in), .irq(irq)
  );

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset(int c);
    m_ptr[c] = 0; m_rr0[c] = 'h44; m_rr1[c] = 'h06; m_wr1[c] = 0;
    m_rxen[c] = 0; m_txen[c] = 0; m_bie[c] = 1; m_rxp[c] = 0;
    m_txp[c] = 0; m_rxb[c] = 0; m_txv[c] = 0; m_txd[c] = 0;
  endtask

  function automatic int cond(int c);
    int mode = (m_wr1[c] >> 3) & 3;
    return ((m_wr1[c] & 1) != 0) &&
           ((((m_wr1[c] & 2) != 0) && m_txp[c] != 0) ||
            ((mode == 1 || mode == 2) && m_rxp[c] != 0) ||
            (m_bie[c] != 0 && (m_rr0[c] & 'h80) != 0));
  endfunction

  function automatic logic [7:0] exp_rdata();
    int ch = bus_addr[2] ? 0 : 1;
    if (!(bus_sel && !bus_we)) return 8'h00;
    if (bus_addr[1]) return 8'(m_rxb[ch]);
    case (m_ptr[ch])
      0: return 8'(m_rr0[ch]);
      1: return 8'(m_rr1[ch]);
      3: return (ch == 0) ? 8'((m_rxp[0] << 5) | (m_txp[0] << 4) |
                               (m_rxp[1] << 2) | (m_txp[1] << 1)) : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic compare();
    check("R1", "rdata", 16'(bus_rdata), 16'(exp_rdata()));
    for (int c = 0; c < 2; c++) begin
      check("R10", "rx_ready", 16'(rx_ready[c]),
            16'(m_rxen[c] != 0 && (m_rr0[c] & 1) == 0));
      check("R9", "tx_valid", 16'(tx_valid[c]), 16'(m_txv[c]));
      if (m_txv[c] != 0) check("R9", "tx_data", 16'(tx_data[c*8 +: 8]), 16'(m_txd[c]));
    end
    check("R7", "irq", 16'(irq), 16'(m_irq));
  endtask

  task automatic model_step();
    int nirq, ch, wd, cmd, ra, rb;
    int rdy[2];
    nirq = (cond(0) != 0 || cond(1) != 0);
    for (int c = 0; c < 2; c++) rdy[c] = (m_rxen[c] != 0 && (m_rr0[c] & 1) == 0);
    m_txv[0] = 0; m_txv[1] = 0;
    if (rst) begin
      model_reset(0); model_reset(1); m_irq = 0;
      return;
    end
    ra = 0; rb = 0;
    ch = bus_addr[2] ? 0 : 1;
    wd = bus_wdata;
    if (bus_sel) begin
      if (bus_we && !bus_addr[1]) begin
        if (m_ptr[ch] == 0) begin
          cmd = (wd >> 3) & 7;
          m_ptr[ch] = (wd & 7) + ((cmd == 1) ? 8 : 0);
          if (cmd == 4 || cmd == 7) m_rxp[ch] = 0;
          if (cmd == 5 || cmd == 7) m_txp[ch] = 0;
        end else begin
          case (m_ptr[ch])
            1:  m_wr1[ch] = wd;
            3:  m_rxen[ch] = wd & 1;
            5:  m_txen[ch] = (wd >> 3) & 1;
            15: m_bie[ch] = (wd >> 7) & 1;
            9:  begin ra = (wd >> 7) & 1; rb = (wd >> 6) & 1; end
            default: ;
          endcase
          m_ptr[ch] = 0;
        end
      end else if (bus_we) begin
        if (m_txen[ch] != 0) begin
          m_txv[ch] = 1; m_txd[ch] = wd; m_rr0[ch] |= 4; m_rr1[ch] |= 1; m_txp[ch] = 1;
        end
      end else if (!bus_addr[1]) begin
        m_ptr[ch] = 0;
      end else begin
        m_rr0[ch] &= ~1; m_rxp[ch] = 0;
      end
    end
    for (int c = 0; c < 2; c++) begin
      if (rx_valid[c] && rdy[c] != 0) begin
        m_rr0[c] |= 1; m_rxb[c] = rx_data[c*8 +: 8]; m_rxp[c] = 1;
      end
      if (brk_in[c]) m_rr0[c] |= 'h80;
    end
    if (ra != 0) model_reset(0);
    if (rb != 0) model_reset(1);
    m_irq = nirq;
  endtask

  task automatic tick();
    #1; compare();
    @(posedge clk); model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    bus_sel = 0; rx_valid = '0; brk_in = '0; tick();
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; tick(); bus_sel = 0;
  endtask

  task automatic rd(logic [2:0] a);
    bus_sel = 1; bus_we = 0; bus_addr = a; tick(); bus_sel = 0;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [7:0] e, string req);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1; check(req, "read value", 16'(bus_rdata), 16'(e));
    #0; tick(); bus_sel = 0;
  endtask

  task automatic push(int c, logic [7:0] d);
    rx_valid = '0; rx_valid[c] = 1'b1; rx_data[c*8 +: 8] = d; tick(); rx_valid = '0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_P*150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) begin @(posedge clk); model_step(); end
    @(negedge clk); rst = 0;
    // R6 reset state
    check("R6", "irq after reset", 16'(irq), 16'h0);
    rd_chk(A_CTL, 8'h44, "R6");
    // R1 address bit 0 ignored, R2 pointer load
    wr(3'b101, 8'h01); rd_chk(A_CTL, 8'h06, "R2");
    wr(A_CTL, 8'h03);  rd_chk(A_CTL, 8'h00, "R8");
    // R9 dropped write, then accepted
    wr(A_DAT, 8'h11); check("R9", "tx dropped", 16'(tx_valid[0]), 16'h0);
    wr(A_CTL, 8'h05); wr(A_CTL, 8'h08);
    wr(A_DAT, 8'h5A);
    check("R9", "tx pulse", 16'(tx_valid[0]), 16'h1);
    check("R9", "tx byte", 16'(tx_data[7:0]), 16'h5A);
    idle(); check("R9", "tx one cycle", 16'(tx_valid[0]), 16'h0);
    wr(A_CTL, 8'h01); rd_chk(A_CTL, 8'h07, "R9");
    wr(A_CTL, 8'h03); rd_chk(A_CTL, 8'h10, "R8");
    // R7 registered interrupt
    wr(A_CTL, 8'h01); wr(A_CTL, 8'h03);
    check("R7", "irq lag", 16'(irq), 16'h0);
    idle(); check("R7", "irq tx", 16'(irq), 16'h1);
    // R4 clear tx
    wr(A_CTL, 8'h28); idle(); check("R4", "irq cleared", 16'(irq), 16'h0);
    wr(A_CTL, 8'h03); rd_chk(A_CTL, 8'h00, "R4");
    // R10 receive on B
    wr(B_CTL, 8'h03); wr(B_CTL, 8'h01);
    check("R10", "ready", 16'(rx_ready[1]), 16'h1);
    push(1, 8'hC3); check("R10", "busy", 16'(rx_ready[1]), 16'h0);
    push(1, 8'h77);
    wr(B_CTL, 8'h01); wr(B_CTL, 8'h09); idle();
    check("R7", "irq rx", 16'(irq), 16'h1);
    wr(A_CTL, 8'h03); rd_chk(A_CTL, 8'h04, "R8");
    wr(B_CTL, 8'h03); rd_chk(B_CTL, 8'h00, "R8");
    rd_chk(B_DAT, 8'hC3, "R10");
    idle();
    check("R10", "ready again", 16'(rx_ready[1]), 16'h1);
    check("R10", "irq after read", 16'(irq), 16'h0);
    // R4 clear both leaves RR0 bit 0
    push(1, 8'h05); wr(B_CTL, 8'h38); rd_chk(B_CTL, 8'h45, "R4");
    check("R4", "still busy", 16'(rx_ready[1]), 16'h0);
    rd(B_DAT);
    // R11 break
    brk_in = 2'b01; tick(); brk_in = '0; idle();
    check("R11", "irq break", 16'(irq), 16'h1);
    rd_chk(A_CTL, 8'hC4, "R11");
    // R5 reset A only
    wr(A_CTL, 8'h09); wr(A_CTL, 8'h80); idle();
    check("R5", "irq after A reset", 16'(irq), 16'h0);
    rd_chk(A_CTL, 8'h44, "R5");
    wr(A_DAT, 8'h22); check("R5", "tx disabled", 16'(tx_valid[0]), 16'h0);
    check("R5", "B untouched", 16'(rx_ready[1]), 16'h1);
    wr(A_CTL, 8'h09); wr(A_CTL, 8'h40);
    check("R5", "B reset", 16'(rx_ready[1]), 16'h0);
    rd_chk(A_CTL, 8'h44, "R3");
    // R3 pointer returns to 0
    wr(B_CTL, 8'h05); wr(B_CTL, 8'h00); rd_chk(B_CTL, 8'h44, "R3");
    wr(B_CTL, 8'h01); rd(B_CTL); rd_chk(B_CTL, 8'h44, "R3");
    wr(B_CTL, 8'h09); wr(B_CTL, 8'hC0); rd_chk(A_CTL, 8'h44, "R5");
    // R2 point-high reaches register 15
    wr(A_CTL, 8'h01); wr(A_CTL, 8'h01);
    wr(A_CTL, 8'h0F); wr(A_CTL, 8'h00);
    brk_in = 2'b01; tick(); brk_in = '0; idle(); idle();
    check("R2", "break masked", 16'(irq), 16'h0);
    wr(A_CTL, 8'h0F); wr(A_CTL, 8'h80); idle(); idle();
    check("R2", "break unmasked", 16'(irq), 16'h1);
    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      bus_sel   = ($urandom_range(0, 9) < 6);
      bus_we    = $urandom_range(0, 1) == 1;
      bus_addr  = 3'($urandom_range(0, 7));
      bus_wdata = 8'($urandom_range(0, 255));
      rx_valid  = 2'($urandom_range(0, 3));
      rx_data   = 16'($urandom_range(0, 65535));
      brk_in[0] = ($urandom_range(0, 63) == 0);
      brk_in[1] = ($urandom_range(0, 63) == 0);
      tick();
    end
    idle();
    done = 1;
    summary();
    $finish;
  end
endmodule